// File: doc/BRIEF.md
# Sprite Line Compositor with Collision

This block draws up to four sprite records into a 256-pixel line buffer for one scanline and watches for overlap between sprites as it draws. A sprite evaluator loads the records into numbered slots, where slot 0 has the highest priority. It then starts a draw pass. The engine handles one pixel slot per clock. It walks from the highest loaded slot down to slot 0, so that a higher-priority sprite is written last and wins where sprites overlap. A separate one-bit-per-pixel occupancy map records every pattern bit that has been placed on the line. When a sprite lands on a pixel that is already marked, a collision is recorded.

The line buffer has two banks. While one line is being composed, the video output stage reads the line composed before it through a registered pixel-read port. A line-boundary strobe swaps the banks and clears both the new compose bank and the occupancy map.

The same strobe commits the status events gathered during the line: frame, fifth sprite with its index, and collision. The status flags are sticky. A host read strobe clears them.

Top module: `sprite_line_compositor`

## Requirements
- R1: Where opaque pixels of two sprites overlap, the pixel shows the colour of the lower-numbered slot. Slots are drawn from slot cnt-1 down to slot 0.
- R2: A sprite with colour 0 writes no colour, but its set pattern bits still mark occupancy and take part in collision.
- R3: A set pattern bit that lands on a pixel already marked on the same line raises the collision flag, status bit 5, at the next line_start.
- R4: Each line_start clears the occupancy map and the colour bank that becomes the compose bank. Overlap between sprites drawn on different lines is not a collision, and pixels no sprite covers read 0.
- R5: Status bits are: bit 7 frame (from vsync_in), bit 6 fifth sprite (from fifth_in), bit 5 collision, bits 4:0 the fifth-sprite index. Events gathered during a line change status only at line_start.
- R6: stat_rd clears bits 7, 6 and 5 in the next cycle and keeps bits 4:0. An event committed in the same cycle as a read remains set.
- R7: rd_color gives, one cycle after rd_x, the pixel of the line composed before the most recent line_start. The line now being composed is not visible until the next line_start.
- R8: The pixel position is rec_x + slot offset - 32*rec_ec. Positions below 0 or at 256 and above are dropped.
- R9: Pattern bit 15 is the leftmost pixel. An 8-wide sprite uses bits 15:8. A 16-wide sprite (rec_wide=1) uses all 16 bits.
- R10: With rec_mag=1, each pattern bit covers two adjacent pixels, which doubles the sprite width.
- R11: After draw_go with draw_cnt=n>0, busy is high for exactly the sum of the n sprite widths in cycles, starting the cycle after draw_go. A draw_go while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rec_we | input | 1 | Write the record fields into slot rec_idx |
| rec_idx | input | 2 | Record slot, 0 is highest priority |
| rec_x | input | 8 | Sprite left position |
| rec_color | input | 4 | Sprite colour, 0 is transparent |
| rec_ec | input | 1 | Shift the sprite 32 pixels left |
| rec_wide | input | 1 | 16-wide pattern instead of 8 |
| rec_mag | input | 1 | Double each pattern bit horizontally |
| rec_pat | input | 16 | Pattern bits, bit 15 leftmost |
| draw_go | input | 1 | Start drawing draw_cnt loaded slots |
| draw_cnt | input | 3 | Number of active slots, 0 to 4 |
| busy | output | 1 | Draw pass in progress |
| line_start | input | 1 | Scanline boundary: swap banks, clear, commit status |
| fifth_in | input | 1 | Fifth-sprite event for this line |
| fifth_idx | input | 5 | Index of the fifth sprite |
| vsync_in | input | 1 | Frame event |
| stat_rd | input | 1 | Host read strobe of status |
| status | output | 8 | Status register |
| rd_x | input | 8 | Readout pixel address |
| rd_color | output | 4 | Readout pixel colour, one cycle after rd_x |

## Verification
On every cycle, the assertions check the following:
- the draw engine never moves back to a higher slot during a pass, and ends only after slot 0;
- no collision can appear in the cycle after a line clear;
- status holds still unless a line boundary or a read occurs;
- a read clears the three flags while the index stays put.

Only the bench scenarios can show the following, because they need a reference model of the whole line:
- the pixel-exact result of priority, transparency, early-clock shift, edge clipping, wide patterns and magnification;
- that collisions are found, or not found, for the right overlaps;
- that readout lags composition by exactly one line.

// File: rtl/sprc_pkg.sv
package sprc_pkg;
   localparam int LINE_W  = 256;
   localparam int XW      = $clog2(LINE_W);
   localparam int COLOR_W = 4;
   localparam int PAT_W   = 16;

   typedef struct packed {
      logic [XW-1:0]      x;
      logic [COLOR_W-1:0] color;
      logic               ec;
      logic               wide;
      logic               mag;
      logic [PAT_W-1:0]   pat;
   } spr_rec_t;
endpackage

// File: rtl/sprc_engine.sv
module sprc_engine
   import sprc_pkg::*;
#(
   parameter int NSPR     = 4,
   parameter int EC_SHIFT = 32,
   localparam int IW      = (NSPR > 1) ? $clog2(NSPR) : 1,
   localparam int CW      = $clog2(NSPR + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               abort,
   input  logic               rec_we,
   input  logic [IW-1:0]      rec_idx,
   input  spr_rec_t           rec_in,
   input  logic               go,
   input  logic [CW-1:0]      cnt,
   output logic               busy,
   output logic               wr_en,
   output logic [XW-1:0]      wr_x,
   output logic [COLOR_W-1:0] wr_color
);
   localparam int PXW = 5;

   spr_rec_t           recs [NSPR];
   logic               busy_q;
   logic [IW-1:0]      sp;
   logic [PXW-1:0]     px;
   spr_rec_t           cur;
   logic [PXW:0]       wdt;
   logic               last;
   logic [3:0]         bidx;
   logic               pbit;
   int                 xi;
   logic               onscreen;

   assign cur = recs[sp];

   always_comb begin
      if (cur.wide) wdt = cur.mag ? 6'd32 : 6'd16;
      else          wdt = cur.mag ? 6'd16 : 6'd8;
      last     = ({1'b0, px} == (wdt - 6'd1));
      bidx     = cur.mag ? px[4:1] : px[3:0];
      pbit     = cur.pat[4'd15 - bidx];
      xi       = int'(cur.x) + int'(px) - (cur.ec ? EC_SHIFT : 0);
      onscreen = (xi >= 0) && (xi < LINE_W);
   end

   assign busy     = busy_q;
   assign wr_en    = busy_q && pbit && onscreen;
   assign wr_x     = xi[XW-1:0];
   assign wr_color = cur.color;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSPR; i++) recs[i] <= '0;
      end else if (rec_we) begin
         recs[rec_idx] <= rec_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sp     <= '0;
         px     <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         px     <= '0;
      end else if (!busy_q) begin
         if (go && cnt != '0) begin
            busy_q <= 1'b1;
            sp     <= IW'(cnt - CW'(1));
            px     <= '0;
         end
      end else if (last) begin
         px <= '0;
         if (sp == '0) busy_q <= 1'b0;
         else          sp     <= sp - IW'(1);
      end else begin
         px <= px + PXW'(1);
      end
   end

   // R1: slots are visited in falling order within a pass
   assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$past(abort)) |-> (sp <= $past(sp)));

   // R11: a pass ends only after slot 0 has been drawn
   assert_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_q) && !$past(abort)) |-> ($past(sp) == '0));
endmodule

// File: rtl/sprc_linebuf.sv
module sprc_linebuf
   import sprc_pkg::*;
#(
   parameter bit READ_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               swap,
   input  logic               wr_en,
   input  logic [XW-1:0]      wr_x,
   input  logic [COLOR_W-1:0] wr_color,
   output logic               hit,
   input  logic [XW-1:0]      rd_x,
   output logic [COLOR_W-1:0] rd_color
);
   logic [COLOR_W-1:0] lb [2][LINE_W];
   logic [LINE_W-1:0]  occ;
   logic               cb;

   assign hit = wr_en && !swap && occ[wr_x];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cb  <= 1'b0;
         occ <= '0;
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < LINE_W; i++) lb[b][i] <= '0;
      end else if (swap) begin
         cb  <= ~cb;
         occ <= '0;
         for (int i = 0; i < LINE_W; i++) lb[~cb][i] <= '0;
      end else if (wr_en) begin
         occ[wr_x] <= 1'b1;
         if (wr_color != '0) lb[cb][wr_x] <= wr_color;
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [COLOR_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= lb[~cb][rd_x];
         end
         assign rd_color = rd_q;
      end else begin : g_rd_comb
         assign rd_color = lb[~cb][rd_x];
      end
   endgenerate

   // R4: the cycle after a clear no pixel can already be marked
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(swap) |-> !hit);
endmodule

// File: rtl/sprc_status.sv
module sprc_status #(
   parameter int IDXW   = 5,
   localparam int STAT_W = IDXW + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              hit,
   input  logic              fifth_in,
   input  logic [IDXW-1:0]   fifth_idx,
   input  logic              vsync_in,
   input  logic              rd,
   output logic [STAT_W-1:0] status
);
   logic            pend_c, pend_f, pend_5;
   logic [IDXW-1:0] pend_idx;
   logic            flag_c, flag_f, flag_5;
   logic [IDXW-1:0] idx;
   logic            n_c, n_f, n_5;
   logic [IDXW-1:0] n_idx;

   always_comb begin
      n_c   = pend_c | hit;
      n_f   = pend_f | vsync_in;
      n_5   = pend_5 | fifth_in;
      n_idx = fifth_in ? fifth_idx : pend_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {pend_c, pend_f, pend_5} <= '0;
         pend_idx                 <= '0;
         {flag_c, flag_f, flag_5} <= '0;
         idx                      <= '0;
      end else if (tick) begin
         {pend_c, pend_f, pend_5} <= '0;
         pend_idx                 <= '0;
         flag_c <= (rd ? 1'b0 : flag_c) | n_c;
         flag_f <= (rd ? 1'b0 : flag_f) | n_f;
         flag_5 <= (rd ? 1'b0 : flag_5) | n_5;
         if (n_5) idx <= n_idx;
      end else begin
         pend_c   <= n_c;
         pend_f   <= n_f;
         pend_5   <= n_5;
         pend_idx <= n_idx;
         if (rd) {flag_c, flag_f, flag_5} <= '0;
      end
   end

   assign status = {flag_f, flag_5, flag_c, idx};

   // R5: status moves only at a line boundary or a read
   assert_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !rd) |=> $stable(status));

   // R6: a read without a boundary leaves all three flags low
   assert_rdclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !tick) |=> (status[STAT_W-1:IDXW] == 3'b000));

   // R6: the index field holds between boundaries
   assert_idxhold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(status[IDXW-1:0]));
endmodule

// File: rtl/sprite_line_compositor.sv
module sprite_line_compositor
   import sprc_pkg::*;
#(
   parameter int  NSPR      = 4,
   parameter int  SPR_TOTAL = 32,
   parameter int  EC_SHIFT  = 32,
   parameter bit  READ_REG  = 1'b1,
   localparam int IW        = (NSPR > 1) ? $clog2(NSPR) : 1,
   localparam int CW        = $clog2(NSPR + 1),
   localparam int IDXW      = $clog2(SPR_TOTAL),
   localparam int STAT_W    = IDXW + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rec_we,
   input  logic [IW-1:0]      rec_idx,
   input  logic [XW-1:0]      rec_x,
   input  logic [COLOR_W-1:0] rec_color,
   input  logic               rec_ec,
   input  logic               rec_wide,
   input  logic               rec_mag,
   input  logic [PAT_W-1:0]   rec_pat,
   input  logic               draw_go,
   input  logic [CW-1:0]      draw_cnt,
   output logic               busy,
   input  logic               line_start,
   input  logic               fifth_in,
   input  logic [IDXW-1:0]    fifth_idx,
   input  logic               vsync_in,
   input  logic               stat_rd,
   output logic [STAT_W-1:0]  status,
   input  logic [XW-1:0]      rd_x,
   output logic [COLOR_W-1:0] rd_color
);
   initial begin
      assert (NSPR >= 1 && NSPR <= 8) else $error("NSPR out of range");
      assert (SPR_TOTAL >= NSPR) else $error("SPR_TOTAL below NSPR");
      assert (EC_SHIFT > 0 && EC_SHIFT < LINE_W) else $error("EC_SHIFT out of range");
   end

   spr_rec_t           rec_in;
   logic               wr_en;
   logic [XW-1:0]      wr_x;
   logic [COLOR_W-1:0] wr_color;
   logic               hit;

   assign rec_in = '{x: rec_x, color: rec_color, ec: rec_ec,
                     wide: rec_wide, mag: rec_mag, pat: rec_pat};

   sprc_engine #(.NSPR(NSPR), .EC_SHIFT(EC_SHIFT)) u_engine (
      .clk(clk), .rst_n(rst_n), .abort(line_start),
      .rec_we(rec_we), .rec_idx(rec_idx), .rec_in(rec_in),
      .go(draw_go), .cnt(draw_cnt), .busy(busy),
      .wr_en(wr_en), .wr_x(wr_x), .wr_color(wr_color));

   sprc_linebuf #(.READ_REG(READ_REG)) u_linebuf (
      .clk(clk), .rst_n(rst_n), .swap(line_start),
      .wr_en(wr_en), .wr_x(wr_x), .wr_color(wr_color), .hit(hit),
      .rd_x(rd_x), .rd_color(rd_color));

   sprc_status #(.IDXW(IDXW)) u_status (
      .clk(clk), .rst_n(rst_n), .tick(line_start), .hit(hit),
      .fifth_in(fifth_in), .fifth_idx(fifth_idx), .vsync_in(vsync_in),
      .rd(stat_rd), .status(status));
endmodule

// File: tb/sim_sprite_line_compositor.sv
`timescale 1ns/1ps
module sim_sprite_line_compositor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rec_we = 0;
   logic [1:0]  rec_idx = 0;
   logic [7:0]  rec_x = 0;
   logic [3:0]  rec_color = 0;
   logic        rec_ec = 0, rec_wide = 0, rec_mag = 0;
   logic [15:0] rec_pat = 0;
   logic        draw_go = 0;
   logic [2:0]  draw_cnt = 0;
   logic        busy;
   logic        line_start = 0, fifth_in = 0, vsync_in = 0, stat_rd = 0;
   logic [4:0]  fifth_idx = 0;
   logic [7:0]  status;
   logic [7:0]  rd_x = 0;
   logic [3:0]  rd_color;

   always #2.5 clk = ~clk;

   sprite_line_compositor u0 (.*);

   int tests = 0, fails = 0;
   bit done = 0;

   logic [7:0]  tx [4];
   logic [3:0]  tc [4];
   logic        te [4], tw [4], tm [4];
   logic [15:0] tp [4];
   logic [3:0]  exp_line [256];
   logic [3:0]  prev_line [256];
   bit          exp_coll;
   logic [4:0]  exp_idx = 0;

   function automatic int spr_w(int i);
      return (tw[i] ? 16 : 8) * (tm[i] ? 2 : 1);
   endfunction

   task automatic model(int cnt);
      bit occ [256];
      for (int x = 0; x < 256; x++) begin exp_line[x] = 0; occ[x] = 0; end
      exp_coll = 0;
      for (int i = cnt - 1; i >= 0; i--) begin
         for (int p = 0; p < spr_w(i); p++) begin
            int bi = tm[i] ? p / 2 : p;
            int xi = int'(tx[i]) + p - (te[i] ? 32 : 0);
            if (tp[i][15 - bi] && xi >= 0 && xi < 256) begin
               if (occ[xi]) exp_coll = 1;
               occ[xi] = 1;
               if (tc[i] != 0) exp_line[xi] = tc[i];
            end
         end
      end
   endtask

   task automatic check(string tag, string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic set_spr(int i, int x, int c, bit e, bit w, bit m, int p);
      tx[i] = 8'(x); tc[i] = 4'(c); te[i] = e; tw[i] = w; tm[i] = m; tp[i] = 16'(p);
   endtask

   // read the visible line and count mismatches against ref (0 exp, 1 prev)
   task automatic read_cmp(string tag, bit use_prev);
      int errs = 0, fa = 0, fe = 0;
      for (int x = 0; x < 256; x++) begin
         rd_x = 8'(x);
         @(negedge clk);
         if (rd_color != (use_prev ? prev_line[x] : exp_line[x])) begin
            if (errs == 0) begin fa = rd_color; fe = use_prev ? prev_line[x] : exp_line[x]; end
            errs++;
         end
      end
      check(tag, use_prev ? "old line still shown" : "line pixels", errs == 0 ? fe : fa, fe);
   endtask

   task automatic run_line(string ltag, string ctag, int cnt, bit f5, int fidx,
                           bit vs, bit rego);
      int cyc = 0, expc = 0;
      for (int i = 0; i < cnt; i++) begin
         rec_we = 1; rec_idx = 2'(i); rec_x = tx[i]; rec_color = tc[i];
         rec_ec = te[i]; rec_wide = tw[i]; rec_mag = tm[i]; rec_pat = tp[i];
         @(negedge clk);
         expc += spr_w(i);
      end
      rec_we = 0;
      model(cnt);
      draw_go = 1; draw_cnt = 3'(cnt);
      @(negedge clk);
      draw_go = 0;
      while (busy && cyc < 1000) begin
         cyc++;
         draw_go = (rego && cyc == 3);
         draw_cnt = rego ? 3'd1 : draw_cnt;
         @(negedge clk);
      end
      draw_go = 0;
      check("R11", "busy cycles", cyc, expc);
      if (f5) begin fifth_in = 1; fifth_idx = 5'(fidx); @(negedge clk); fifth_in = 0; end
      if (vs) begin vsync_in = 1; @(negedge clk); vsync_in = 0; end
      check("R5", "flags before boundary", int'(status[7:5]), 0);
      read_cmp("R7", 1);
      line_start = 1;
      @(negedge clk);
      line_start = 0;
      if (f5) exp_idx = 5'(fidx);
      check(ctag, "status after boundary", int'(status),
            int'({vs, f5, exp_coll, exp_idx}));
      read_cmp(ltag, 0);
      for (int x = 0; x < 256; x++) prev_line[x] = exp_line[x];
      stat_rd = 1;
      @(negedge clk);
      stat_rd = 0;
      check("R6", "status after read", int'(status), int'({3'b000, exp_idx}));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      for (int x = 0; x < 256; x++) prev_line[x] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R5", "reset status", int'(status), 0);
      check("R11", "reset busy", int'(busy), 0);
      check("R7", "reset readout", int'(rd_color), 0);

      // R1/R3 overlap, plus a draw_go while busy (R11)
      set_spr(0, 10, 5, 0, 0, 0, 16'hFF00);
      set_spr(1, 14, 9, 0, 0, 0, 16'hFF00);
      run_line("R1", "R3", 2, 0, 0, 0, 1);
      check("R1", "pixel 15 colour", int'(prev_line[15]), 5);
      // R2 transparent sprite on top still collides
      set_spr(0, 40, 0, 0, 0, 0, 16'hFF00);
      set_spr(1, 40, 7, 0, 0, 0, 16'hFF00);
      run_line("R2", "R2", 2, 1, 21, 0, 0);
      check("R2", "pixel 41 colour", int'(prev_line[41]), 7);
      // R4 same spot next line, single sprite: no collision
      set_spr(0, 40, 3, 0, 0, 0, 16'hF000);
      run_line("R4", "R4", 1, 0, 0, 1, 0);
      // R8 early-clock left clip and right clip
      set_spr(0, 20, 3, 1, 1, 1, 16'hFFFF);
      set_spr(1, 250, 4, 0, 1, 0, 16'hFFFF);
      run_line("R8", "R8", 2, 0, 0, 0, 0);
      check("R8", "pixel 0 colour", int'(prev_line[0]), 3);
      // R9 wide pattern ends
      set_spr(0, 100, 6, 0, 1, 0, 16'h8001);
      run_line("R9", "R9", 1, 0, 0, 0, 0);
      check("R9", "pixel 115 colour", int'(prev_line[115]), 6);
      // R10 magnified narrow
      set_spr(0, 60, 2, 0, 0, 1, 16'hA000);
      run_line("R10", "R10", 1, 0, 0, 0, 0);
      check("R10", "pixel 61 colour", int'(prev_line[61]), 2);
      // empty line
      run_line("R4", "R5", 0, 1, 3, 1, 0);

      // R6 event committed in the same cycle as a read
      vsync_in = 1; @(negedge clk); vsync_in = 0;
      line_start = 1; stat_rd = 1; @(negedge clk);
      line_start = 0; stat_rd = 0;
      check("R6", "frame flag kept on read+boundary", int'(status[7]), 1);
      stat_rd = 1; @(negedge clk); stat_rd = 0;
      check("R6", "frame flag cleared", int'(status[7]), 0);
      model(0);
      for (int x = 0; x < 256; x++) prev_line[x] = 0;

      for (int n = 0; n < 30; n++) begin
         int cnt = $urandom_range(0, 4);
         for (int i = 0; i < 4; i++)
            set_spr(i, $urandom_range(0, 255),
                    ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(1, 15),
                    ($urandom_range(0, 7) == 0), $urandom_range(0, 1),
                    $urandom_range(0, 1), $urandom_range(0, 65535));
         run_line("R1", "R3", cnt, ($urandom_range(0, 3) == 0),
                  $urandom_range(0, 31), ($urandom_range(0, 3) == 0), 0);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule